// File: doc/BRIEF.md
# Cyclic Microcode Sequencer

This block steers a group of processing units that share one data bus. It holds a short microcode program and drives a wide control bus, one program word per clock. Address 0 is reserved for a safe word in which every unit does nothing. That word is on the bus while reset is held and while the sequencer waits between passes. A pass walks the program from word 1 up to the last word, N = TICKS + 1, so the memory is TICKS + 2 words deep. After word N, the sequencer either starts the next pass at once or parks on word 0. The `pass_go` input makes that choice. The system drives it high when a new pass may begin, for example when an external exchange allows it or when free-running operation is wanted.

The block also forms the shared data bus as the bitwise OR of every unit's output word, so a unit that is not the selected source must drive zero. It reports the position in the pass on three flags and packs two debug bytes for bring-up.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high, and at the first check after it falls (before any edge with `rst` low), `ctrl_bus` equals `NOP_WORD` and all three flags are low. A reset in the middle of a pass abandons the pass.
- R2: When the sequencer sits on word 0 with `rst` low, a rising edge with `pass_go` high moves it to word 1. A rising edge with `pass_go` low keeps it on word 0.
- R3: Within a pass, the word index rises by one on every rising edge, from 1 to N, whatever the value of `pass_go`.
- R4: On word N, a rising edge with `pass_go` high moves directly to word 1, with no idle word between passes. With `pass_go` low, the edge moves to word 0, which is held until a later edge sees `pass_go` high.
- R5: Word k (1..N) of the program is `PROGRAM[k*CTRL_W-1 : (k-1)*CTRL_W]`. Bit j of `ctrl_bus` carries control signal j of the current word.
- R6: `cycle_begin` is high exactly while word 1 is on the bus.
- R7: `in_cycle` is high exactly while a word from 1 to N is on the bus.
- R8: `cycle_end` is high exactly while word N is on the bus.
- R9: `data_bus` is the bitwise OR of the NUM_UNITS words in `unit_data`. Unit u occupies bits [u*DATA_W +: DATA_W].
- R10: `debug_status` is {`cycle_begin`, `in_cycle`, `cycle_end`, `data_bus[4:0]`}, with `cycle_begin` in bit 7.
- R11: `debug_fold` is the bitwise OR of all DATA_W/8 bytes of `data_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pass_go | input | 1 | High when a new pass may start |
| unit_data | input | NUM_UNITS*DATA_W | Output words of all units, concatenated |
| ctrl_bus | output | CTRL_W | Current microcode word |
| data_bus | output | DATA_W | OR of all unit outputs |
| cycle_begin | output | 1 | First word of a pass |
| in_cycle | output | 1 | A program word is being issued |
| cycle_end | output | 1 | Last word of a pass |
| debug_status | output | 8 | Flags and low data bits |
| debug_fold | output | 8 | OR of the data bytes |

## Verification
All state in this block lives in the word index, and every value of that index shows on `ctrl_bus` and the flags in the same cycle. A wrong index is therefore visible at the ports one clock after the faulty edge. The bench uses a program in which every word is distinct and differs from the no-op word, so any skipped, repeated or stalled word, and any early or late restart, shows up as a bus mismatch on that clock. Stalled restarts, back-to-back passes and a reset in mid-pass are all exercised.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int CTRL_W = 16,
  parameter int TICKS = 6,
  parameter int NUM_UNITS = 4,
  parameter int DATA_W = 32,
  parameter logic [CTRL_W-1:0] NOP_WORD = '0,
  parameter logic [(TICKS+1)*CTRL_W-1:0] PROGRAM = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pass_go,
  input  logic [NUM_UNITS*DATA_W-1:0]   unit_data,
  output logic [CTRL_W-1:0]             ctrl_bus,
  output logic [DATA_W-1:0]             data_bus,
  output logic                          cycle_begin,
  output logic                          in_cycle,
  output logic                          cycle_end,
  output logic [7:0]                    debug_status,
  output logic [7:0]                    debug_fold
);
  localparam int LAST  = TICKS + 1;
  localparam int DEPTH = TICKS + 2;
  localparam int PC_W  = $clog2(DEPTH);
  localparam int SLOTS = 1 << PC_W;
  localparam int BYTES = DATA_W / 8;

  logic [PC_W-1:0]   pc;
  logic [CTRL_W-1:0] rom [SLOTS];
  logic              at_idle, at_last;

  for (genvar k = 0; k < SLOTS; k++) begin : g_rom
    if (k == 0 || k > LAST) begin : g_nop
      assign rom[k] = NOP_WORD;
    end else begin : g_word
      assign rom[k] = PROGRAM[(k-1)*CTRL_W +: CTRL_W];
    end
  end

  assign at_idle = (pc == '0);
  assign at_last = (pc == PC_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (at_idle || at_last)
      pc <= pass_go ? PC_W'(1) : '0;
    else
      pc <= pc + PC_W'(1);
  end

  assign ctrl_bus    = rom[pc];
  assign cycle_begin = (pc == PC_W'(1));
  assign in_cycle    = !at_idle;
  assign cycle_end   = at_last;

  always_comb begin
    data_bus = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      data_bus = data_bus | unit_data[u*DATA_W +: DATA_W];
  end

  always_comb begin
    debug_fold = '0;
    for (int b = 0; b < BYTES; b++)
      debug_fold = debug_fold | data_bus[b*8 +: 8];
  end

  assign debug_status = {cycle_begin, in_cycle, cycle_end, data_bus[4:0]};
endmodule

module ucode_sequencer_chk #(
  parameter int PC_W = 3,
  parameter int LAST = 7,
  parameter int CTRL_W = 16,
  parameter logic [CTRL_W-1:0] NOP_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              pass_go,
  input logic [PC_W-1:0]   pc,
  input logic [CTRL_W-1:0] ctrl_bus,
  input logic              cycle_begin,
  input logic              in_cycle,
  input logic              cycle_end
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ctrl_bus == NOP_WORD && !in_cycle && !cycle_begin && !cycle_end));
  // R2
  start_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pc == '0 && pass_go) |=> cycle_begin);
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_cycle && !cycle_end) |=> (pc == $past(pc) + PC_W'(1)));
  // R4
  park_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !pass_go) |=> (!in_cycle && ctrl_bus == NOP_WORD));
  // R6
  begin_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_begin |-> in_cycle);
  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> (in_cycle && pc == PC_W'(LAST)));
endmodule

bind ucode_sequencer ucode_sequencer_chk #(
  .PC_W(PC_W), .LAST(LAST), .CTRL_W(CTRL_W), .NOP_WORD(NOP_WORD)
) u_chk (
  .clk(clk), .rst(rst), .pass_go(pass_go), .pc(pc), .ctrl_bus(ctrl_bus),
  .cycle_begin(cycle_begin), .in_cycle(in_cycle), .cycle_end(cycle_end)
);

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int TK = 4;
  localparam int LASTW = TK + 1;
  localparam int NU = 3;
  localparam int DW = 32;
  localparam logic [CW-1:0] NOP = 12'hA5A;

  function automatic logic [CW-1:0] word_of(int k);
    return CW'((k * 12'h1C3) ^ 12'h0F0);
  endfunction

  function automatic logic [LASTW*CW-1:0] build_prog();
    logic [LASTW*CW-1:0] p = '0;
    for (int k = 1; k <= LASTW; k++) p[(k-1)*CW +: CW] = word_of(k);
    return p;
  endfunction

  localparam logic [LASTW*CW-1:0] PROG = build_prog();

  logic clk = 0, rst = 1, pass_go = 0;
  logic [NU*DW-1:0] unit_data = '0;
  logic [CW-1:0] ctrl_bus;
  logic [DW-1:0] data_bus;
  logic cycle_begin, in_cycle, cycle_end;
  logic [7:0] debug_status, debug_fold;

  ucode_sequencer #(.CTRL_W(CW), .TICKS(TK), .NUM_UNITS(NU), .DATA_W(DW),
                    .NOP_WORD(NOP), .PROGRAM(PROG)) u_ucode_sequencer (
    .clk(clk), .rst(rst), .pass_go(pass_go), .unit_data(unit_data),
    .ctrl_bus(ctrl_bus), .data_bus(data_bus), .cycle_begin(cycle_begin),
    .in_cycle(in_cycle), .cycle_end(cycle_end), .debug_status(debug_status),
    .debug_fold(debug_fold));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int m_idx = 0;
  string seq_tag = "R1";
  int unsigned lcg = 32'h1234_5678;

  // reference model: word index after each edge
  always @(posedge clk) begin
    if (rst) begin m_idx <= 0; seq_tag <= "R1"; end
    else if (m_idx == 0) begin m_idx <= pass_go ? 1 : 0; seq_tag <= "R2"; end
    else if (m_idx == LASTW) begin m_idx <= pass_go ? 1 : 0; seq_tag <= "R4"; end
    else begin m_idx <= m_idx + 1; seq_tag <= "R3"; end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [CW-1:0] ew;
    logic [DW-1:0] ed;
    logic [7:0] ef;
    logic eb, ei, ee;
    ew = (m_idx == 0) ? NOP : word_of(m_idx);
    eb = (m_idx == 1); ei = (m_idx != 0); ee = (m_idx == LASTW);
    ed = '0;
    for (int u = 0; u < NU; u++) ed |= unit_data[u*DW +: DW];
    ef = ed[31:24] | ed[23:16] | ed[15:8] | ed[7:0];
    check({seq_tag, "/R5 ctrl_bus"}, 64'(ctrl_bus), 64'(ew));
    check("R6 cycle_begin", 64'(cycle_begin), 64'(eb));
    check("R7 in_cycle", 64'(in_cycle), 64'(ei));
    check("R8 cycle_end", 64'(cycle_end), 64'(ee));
    check("R9 data_bus", 64'(data_bus), 64'(ed));
    check("R10 debug_status", 64'(debug_status), 64'({eb, ei, ee, ed[4:0]}));
    check("R11 debug_fold", 64'(debug_fold), 64'(ef));
  endtask

  task automatic run(int cycles, bit r, bit g);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      rst = r; pass_go = g;
      for (int u = 0; u < NU; u++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        unit_data[u*DW +: DW] = (lcg[3:0] == 4'd0) ? '0 : DW'(lcg);
      end
    end
  endtask

  initial begin
    run(3, 1, 1);     // R1 reset holds the no-op word even with go high
    run(3, 0, 0);     // R2 idle wait after reset
    run(13, 0, 1);    // R3 R4 back-to-back passes
    run(9, 0, 0);     // R4 stall on word 0 after the pass ends
    run(4, 0, 1);     // R2 restart, partial pass
    run(2, 1, 1);     // R1 reset mid-pass
    run(10, 0, 1);
    run(2, 0, 0);
    @(negedge clk); compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule